// File: doc/BRIEF.md
# Interrupt Source Mask and Status Register

This block holds a single 8-bit register that does two jobs. A bus write into it loads the enable mask. A bus read from it returns which enabled sources are pending. Three interrupt sources feed it.

An external input is asynchronous to the block clock. It passes through a synchroniser, and then its rising edges are captured. A FIFO level request is level-sensitive, so its status bit follows the live input while that source is enabled. A timer output is already synchronous, and its rising edges are captured directly.

A captured edge stays pending until software writes a 0 to that source's enable bit. The usual service sequence is: read the status, write the mask with the serviced bits cleared, then write back the original mask. A single registered request line is high while any enabled status bit is set.

Top module: `intr_src_reg`

## Requirements
- R1: After a synchronous active-low reset, the enable mask is 0, `rd_data` reads 0 and `irq_out` is 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the enable mask at that clock edge. Mask bits 1, 3, 4, 6 and 7 have no source and never make any status bit read as 1.
- R3: Bit 0 records a rising edge of `ext_in` while enable bit 0 is 1. The input passes two synchroniser flops before edge detection, so `ext_in` rising before clock edge k shows in `rd_data[0]` after edge k+2.
- R4: Bit 5 records a rising edge of `tmr_out` while enable bit 5 is 1. It shows in `rd_data[5]` after the first clock edge that samples `tmr_out` high when it was low at the previous edge.
- R5: A rising edge that occurs while its enable bit is 0 is discarded. Setting the enable bit later does not make that edge appear.
- R6: A recorded edge stays set after its input falls, for as long as its enable bit stays 1.
- R7: A write with enable bit 0 or 5 equal to 0 clears that recorded edge at the same clock edge. A write that keeps an enable bit at 1 leaves that bit's recorded edge unchanged.
- R8: `rd_data[2]` equals `fifo_lvl` AND enable bit 2, in the same cycle, with no latching.
- R9: `rd_data` bits 1, 3, 4, 6 and 7 always read 0.
- R10: `irq_out` is the OR of the status bits one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_data | input | 8 | New enable mask |
| rd_data | output | 8 | Status of the enabled sources; bits 0, 2 and 5 are used |
| ext_in | input | 1 | Asynchronous external source; its rising edges are captured |
| fifo_lvl | input | 1 | Level-sensitive FIFO request |
| tmr_out | input | 1 | Synchronous timer output; its rising edges are captured |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions check four rules on every cycle:
- an edge bit never latches while its enable is 0;
- a pending edge bit holds until a write clears its enable;
- a disabling write clears the edge bit;
- the request line follows the status one cycle later, and the level bit never reads 1 while it is masked.

Some behaviour only the bench scenarios can show:
- the exact three-edge latency through the synchroniser;
- that an edge seen while disabled is not replayed once the source is enabled;
- that a partial disabling write leaves the other source pending.

The bench therefore sweeps every combination of the three enable bits, with filler values in the unused bits.

// File: rtl/intr_src_pkg.sv
// Package: shared widths and status bit positions for the interrupt
// source mask/status register. The bit positions are decoded by the
// servicing software, so they are fixed here.
package intr_src_pkg;
    localparam int REG_W    = 8;   // register width
    localparam int STAT_W   = 6;   // status bits returned on read
    localparam int EXT_BIT  = 0;   // external input rising edge
    localparam int LVL_BIT  = 2;   // FIFO level request
    localparam int TMR_BIT  = 5;   // timer output rising edge
endpackage

// File: rtl/intr_sync.sv
// Module: intr_sync
// Multi-flop synchroniser for one asynchronous bit.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
module intr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/intr_edge_latch.sv
// Module: intr_edge_latch
// Detects a rising edge on a synchronous input and holds it as pending.
// Capture happens only while the enable bit is 1. A disabling write
// clears the pending flag and takes priority over a new edge.
// Assumes: sig_in is synchronous to clk.
module intr_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic en_bit,
    input  logic dis_wr,
    output logic pend
);
    logic sig_d;
    logic rise;

    // Remember the previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig_in;
    end

    assign rise = sig_in & ~sig_d;

    // Hold the pending flag: clear on disable, set on enabled rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= 1'b0;
        else if (dis_wr)           pend <= 1'b0;
        else if (en_bit && rise)   pend <= 1'b1;
    end

    AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && !pend) |=> !pend);                                   // R5
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !dis_wr) |=> pend);                                     // R6
    AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> !pend);                                               // R7
endmodule

// File: rtl/intr_src_reg.sv
// Module: intr_src_reg
// Interrupt source mask and status register. A write loads the enable
// mask. A read returns the pending status of the enabled sources in
// bits [5:0]. The registered request line is the OR of the status bits.
// Assumes: ext_in is asynchronous; fifo_lvl and tmr_out are synchronous.
module intr_src_reg
    import intr_src_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_in,
    input  logic             fifo_lvl,
    input  logic             tmr_out,
    output logic             irq_out
);
    logic [REG_W-1:0]  en_q;
    logic [STAT_W-1:0] status;
    logic              ext_sync;
    logic              ext_pend;
    logic              tmr_pend;

    // Load the enable mask on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data;
    end

    intr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .sync_out (ext_sync)
    );

    intr_edge_latch u_ext_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (ext_sync),
        .en_bit (en_q[EXT_BIT]),
        .dis_wr (wr_en && !wr_data[EXT_BIT]),
        .pend   (ext_pend)
    );

    intr_edge_latch u_tmr_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (tmr_out),
        .en_bit (en_q[TMR_BIT]),
        .dis_wr (wr_en && !wr_data[TMR_BIT]),
        .pend   (tmr_pend)
    );

    // Assemble the status vector; unused positions read zero.
    always_comb begin
        status          = '0;
        status[EXT_BIT] = ext_pend;
        status[LVL_BIT] = fifo_lvl & en_q[LVL_BIT];
        status[TMR_BIT] = tmr_pend;
    end

    assign rd_data = {{(REG_W-STAT_W){1'b0}}, status};

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |status;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != '0) |=> irq_out);                                    // R10
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) |=> !irq_out);                                   // R10
    AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[LVL_BIT] |-> !rd_data[LVL_BIT]);                           // R8
endmodule

// File: tb/intr_src_reg_tb.sv
module intr_src_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_in = 1'b0;
    logic       fifo_lvl = 1'b0;
    logic       tmr_out = 1'b0;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    intr_src_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_in(ext_in), .fifo_lvl(fifo_lvl),
        .tmr_out(tmr_out), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to the next negedge and settle.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        #1;
    endtask

    // One-cycle mask write; returns at the negedge after it loads.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 rd after reset", rd_data, 8'h00);
        chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
        fifo_lvl = 1'b1;
        step(1);
        chk("R1 mask zero hides level", rd_data, 8'h00);
        fifo_lvl = 1'b0;

        // R3 latency through the synchroniser, R10 registered request
        wr(8'h01);
        @(negedge clk); ext_in = 1'b1;
        step(2);
        chk("R3 not yet after two edges", rd_data, 8'h00);
        step(1);
        chk("R3 visible after third edge", rd_data, 8'h01);
        chk("R10 irq lags status", {7'd0, irq_out}, 8'h00);
        step(1);
        chk("R10 irq set one cycle later", {7'd0, irq_out}, 8'h01);
        ext_in = 1'b0;
        step(2);
        chk("R6 edge held after input falls", rd_data, 8'h01);
        wr(8'h00);
        chk("R7 disable clears ext", rd_data, 8'h00);
        step(1);
        chk("R10 irq clears one cycle later", {7'd0, irq_out}, 8'h00);

        // R4 timer edge, one-cycle latency
        wr(8'h20);
        @(negedge clk); tmr_out = 1'b1;
        step(1);
        chk("R4 timer edge visible", rd_data, 8'h20);
        tmr_out = 1'b0;
        wr(8'h00);

        // R5 edges while disabled are discarded
        @(negedge clk); ext_in = 1'b1; tmr_out = 1'b1;
        step(1); tmr_out = 1'b0;
        step(4);
        wr(8'h21);
        step(4);
        chk("R5 disabled edges not replayed", rd_data, 8'h00);
        ext_in = 1'b0;
        step(4);
        ext_in = 1'b1;
        step(4);
        chk("R5 fresh edge after enable latches", rd_data, 8'h01);

        // R7 partial disable keeps the other bit
        @(negedge clk); tmr_out = 1'b1;
        step(1); tmr_out = 1'b0;
        chk("R7 both pending", rd_data, 8'h21);
        wr(8'h01);
        chk("R7 timer cleared ext kept", rd_data, 8'h01);
        wr(8'h01);
        chk("R7 rewrite of 1 keeps ext", rd_data, 8'h01);
        ext_in = 1'b0;
        wr(8'h00);

        // R8 level follows input with no latching
        wr(8'h04);
        fifo_lvl = 1'b1; #1;
        chk("R8 level same cycle", rd_data, 8'h04);
        fifo_lvl = 1'b0; #1;
        chk("R8 level drops at once", rd_data, 8'h00);
        wr(8'h00);

        // Sweep every enable combination, with filler in the unused bits
        for (int m = 0; m < 8; m++) begin
            logic [7:0] msk;
            logic [7:0] exp;
            msk = {2'(m * 3), m[2], 2'(m + 1), m[1], 1'(m ^ 1), m[0]};
            exp = {2'b00, m[2], 2'b00, m[1], 1'b0, m[0]};
            wr(msk);
            @(negedge clk);
            fifo_lvl = 1'b1; tmr_out = 1'b1; ext_in = 1'b1;
            step(1); tmr_out = 1'b0;
            step(3);
            chk($sformatf("R2 R9 sweep status m=%0d", m), rd_data, exp);
            chk($sformatf("R10 sweep irq m=%0d", m), {7'd0, irq_out}, {7'd0, exp != 8'h00});
            fifo_lvl = 1'b0; ext_in = 1'b0;
            step(1);
            chk($sformatf("R6 R8 sweep after inputs fall m=%0d", m), rd_data, exp & 8'hFB);
            wr(8'h00);
            chk($sformatf("R7 sweep cleared m=%0d", m), rd_data, 8'h00);
            step(1);
            chk($sformatf("R10 sweep irq clear m=%0d", m), {7'd0, irq_out}, 8'h00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule